// File: doc/BRIEF.md
# Count-Delimited Message Receive Framer

This block takes a byte stream that is already aligned to character boundaries and finds message frames in it. It waits for a run of at least two synchronisation characters. It then accepts one of three start characters: data, control or maintenance. Next it captures the fixed header: the length, two flag bits, a response number, a sequence number and a station address. A 16-bit check word guards that header. The decoded header is published only when the header check word matches.

For data and maintenance messages, the framer then passes exactly as many payload bytes as the length field gives. A second, independent 16-bit check word covers only the payload. A control message has no payload, so the framer goes back to hunting as soon as its header check ends. The layers above this block decide what each message means. The character alignment below it is done elsewhere.

Top module: `ddcmp_rx_framer`

## Requirements
- R1: After reset all pulse outputs and `data_valid` are low, and every published header field is zero.
- R2: A start character is accepted only when at least two synchronisation characters (`SYN_CHAR`, default 0x96) come directly before it among the accepted bytes. Any other byte ends the run. A start character without such a run is ignored and produces no output.
- R3: After the start character, the five header bytes are: the length low byte; then a byte whose bits 5:0 are length bits 13:8 and whose bits 7:6 are the flags; then the response number; then the sequence number; then the address.
- R4: The check word is CRC-16 with polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001) from an initial value of zero. It is sent low byte first. The header check word covers the start character and the five header bytes.
- R5: When the header check word matches, `hdr_ok` pulses for one cycle, in the cycle after its last byte. All published fields take the new message's values in that same cycle. At no other time do they change.
- R6: When the header check word does not match, `hdr_crc_err` pulses for one cycle instead of `hdr_ok`. The published fields stay as they were, no payload byte is passed, and the framer goes back to hunting.
- R7: For a message that starts with 0x81 (data) or 0x90 (maintenance), the next `length` bytes are passed on `data_byte`. `data_valid` is high in the cycle after each of these bytes is received.
- R8: The payload check word covers only the payload bytes. `data_end` pulses one cycle after its last byte. `data_crc_err` pulses with it when the payload check word does not match.
- R9: A message that starts with 0x05 (control) has no payload, whatever value its length field holds. The framer goes back to hunting right after the header check word.
- R10: After a message ends or is aborted, a new start character is accepted only after two new synchronisation characters.
- R11: A data message with a length of zero goes straight to the payload check word. That check is computed over no bytes, so its correct value is 0x0000.
- R12: A cycle with `rx_valid` low changes no state and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received character |
| hdr_ok | output | 1 | Header check word matched; fields updated |
| hdr_crc_err | output | 1 | Header check word mismatch; message dropped |
| msg_start | output | 8 | Start character of the last good header |
| msg_count | output | 14 | Payload length |
| msg_flags | output | 2 | Flag bits |
| msg_resp | output | 8 | Response number |
| msg_seq | output | 8 | Sequence number |
| msg_addr | output | 8 | Station address |
| data_valid | output | 1 | Payload byte strobe |
| data_byte | output | 8 | Payload byte |
| data_end | output | 1 | Payload check word received |
| data_crc_err | output | 1 | Payload check word mismatch |

## Verification
The bench builds the block with its default character codes and the full 14-bit length field. It sends short payloads, including length zero and a control message whose length field is not zero. This brings within reach every exit from the frame: a good header, a bad header, a bad payload and an empty payload. Idle gaps are placed inside frames, and the bench sends short or broken synchronisation runs and start characters with no run before them, to exercise the hunt logic.

// File: rtl/ddcmp_rx_pkg.sv
package ddcmp_rx_pkg;
  localparam int CNT_W  = 14;
  localparam int FLAG_W = 2;
  localparam int HDR_BYTES = 5;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_CRC1, ST_DATA, ST_CRC2
  } rx_state_e;

  // one byte through the reflected CRC-16 (x^16+x^15+x^2+1)
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  b);
    logic [15:0] c;
    c = crc_in ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] hdr_count(input logic [7:0] lo,
                                                 input logic [7:0] hi);
    logic [15:0] w;
    w = {hi, lo};
    return w[CNT_W-1:0];
  endfunction

  function automatic logic [FLAG_W-1:0] hdr_flags(input logic [7:0] hi);
    return hi[7:8-FLAG_W];
  endfunction
endpackage

// File: rtl/ddcmp_crc_acc.sv
module ddcmp_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic        seed,
  input  logic [7:0]  din,
  output logic [15:0] crc_nxt
);
  import ddcmp_rx_pkg::*;
  logic [15:0] crc_q;

  assign crc_nxt = crc16_step(seed ? 16'h0000 : crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= 16'h0000;
    else if (upd)      crc_q <= crc_nxt;
  end
endmodule

// File: rtl/ddcmp_hdr_fields.sv
module ddcmp_hdr_fields
  import ddcmp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [7:0]        start_byte,
  input  logic              cap_en,
  input  logic [2:0]        cap_idx,
  input  logic [7:0]        cap_byte,
  input  logic              publish,
  output logic [CNT_W-1:0]  stage_count,
  output logic [7:0]        stage_start,
  output logic [7:0]        pub_start,
  output logic [CNT_W-1:0]  pub_count,
  output logic [FLAG_W-1:0] pub_flags,
  output logic [7:0]        pub_resp,
  output logic [7:0]        pub_seq,
  output logic [7:0]        pub_addr
);
  logic [7:0] stage_q [HDR_BYTES];
  logic [7:0] start_q;

  assign stage_count = hdr_count(stage_q[0], stage_q[1]);
  assign stage_start = start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 8'h00;
    else if (start_en) start_q <= start_byte;
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[g] <= 8'h00;
      else if (cap_en && cap_idx == 3'(g)) stage_q[g] <= cap_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pub_start <= '0; pub_count <= '0; pub_flags <= '0;
      pub_resp  <= '0; pub_seq   <= '0; pub_addr  <= '0;
    end else if (publish) begin
      pub_start <= start_q;
      pub_count <= stage_count;
      pub_flags <= hdr_flags(stage_q[1]);
      pub_resp  <= stage_q[2];
      pub_seq   <= stage_q[3];
      pub_addr  <= stage_q[4];
    end
  end
endmodule

// File: rtl/ddcmp_rx_framer.sv
module ddcmp_rx_framer #(
  parameter logic [7:0] SYN_CHAR = 8'h96,
  parameter logic [7:0] SOH_CHAR = 8'h81,
  parameter logic [7:0] ENQ_CHAR = 8'h05,
  parameter logic [7:0] DLE_CHAR = 8'h90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        hdr_ok,
  output logic        hdr_crc_err,
  output logic [7:0]  msg_start,
  output logic [13:0] msg_count,
  output logic [1:0]  msg_flags,
  output logic [7:0]  msg_resp,
  output logic [7:0]  msg_seq,
  output logic [7:0]  msg_addr,
  output logic        data_valid,
  output logic [7:0]  data_byte,
  output logic        data_end,
  output logic        data_crc_err
);
  import ddcmp_rx_pkg::*;

  rx_state_e        state_q;
  logic [1:0]       syn_run_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] remain_q;

  // named internal events
  logic is_syn, is_start, start_seen, hdr_good, hdr_bad, crc_clr, crc_upd, crc_seed;
  logic [15:0]      crc_nxt;
  logic [CNT_W-1:0] stage_count;
  logic [7:0]       stage_start;

  assign is_syn     = (rx_byte == SYN_CHAR);
  assign is_start   = (rx_byte == SOH_CHAR) || (rx_byte == ENQ_CHAR) || (rx_byte == DLE_CHAR);
  assign start_seen = rx_valid && state_q == ST_HUNT && !is_syn && is_start && syn_run_q == 2'd2;
  assign hdr_good   = rx_valid && state_q == ST_CRC1 && idx_q == 3'd1 && crc_nxt == 16'h0000;
  assign hdr_bad    = rx_valid && state_q == ST_CRC1 && idx_q == 3'd1 && crc_nxt != 16'h0000;
  assign crc_upd    = rx_valid && (state_q != ST_HUNT || start_seen);
  assign crc_seed   = start_seen;
  assign crc_clr    = hdr_good;

  ddcmp_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .seed(crc_seed), .din(rx_byte), .crc_nxt(crc_nxt)
  );

  ddcmp_hdr_fields u_fields (
    .clk(clk), .rst_n(rst_n),
    .start_en(start_seen), .start_byte(rx_byte),
    .cap_en(rx_valid && state_q == ST_HDR), .cap_idx(idx_q), .cap_byte(rx_byte),
    .publish(hdr_good), .stage_count(stage_count), .stage_start(stage_start),
    .pub_start(msg_start), .pub_count(msg_count), .pub_flags(msg_flags),
    .pub_resp(msg_resp), .pub_seq(msg_seq), .pub_addr(msg_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT; syn_run_q <= 2'd0; idx_q <= 3'd0; remain_q <= '0;
      hdr_ok <= 1'b0; hdr_crc_err <= 1'b0; data_valid <= 1'b0;
      data_byte <= 8'h00; data_end <= 1'b0; data_crc_err <= 1'b0;
    end else begin
      hdr_ok       <= hdr_good;
      hdr_crc_err  <= hdr_bad;
      data_valid   <= 1'b0;
      data_end     <= 1'b0;
      data_crc_err <= 1'b0;
      if (rx_valid) begin
        unique case (state_q)
          ST_HUNT: begin
            if (is_syn) syn_run_q <= (syn_run_q == 2'd2) ? 2'd2 : syn_run_q + 2'd1;
            else if (start_seen) begin
              state_q <= ST_HDR; idx_q <= 3'd0; syn_run_q <= 2'd0;
            end else syn_run_q <= 2'd0;
          end
          ST_HDR: begin
            if (idx_q == 3'(HDR_BYTES - 1)) begin
              state_q <= ST_CRC1; idx_q <= 3'd0;
            end else idx_q <= idx_q + 3'd1;
          end
          ST_CRC1: begin
            if (idx_q == 3'd0) idx_q <= 3'd1;
            else begin
              idx_q <= 3'd0;
              if (hdr_bad || stage_start == ENQ_CHAR) state_q <= ST_HUNT;
              else if (stage_count == '0) state_q <= ST_CRC2;
              else begin
                state_q <= ST_DATA; remain_q <= stage_count;
              end
            end
          end
          ST_DATA: begin
            data_valid <= 1'b1;
            data_byte  <= rx_byte;
            remain_q   <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
              state_q <= ST_CRC2; idx_q <= 3'd0;
            end
          end
          ST_CRC2: begin
            if (idx_q == 3'd0) idx_q <= 3'd1;
            else begin
              idx_q <= 3'd0; state_q <= ST_HUNT;
              data_end <= 1'b1;
              data_crc_err <= (crc_nxt != 16'h0000);
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddcmp_rx_checker.sv
module ddcmp_rx_checker #(
  parameter logic [7:0] ENQ_CHAR = 8'h05
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       hdr_ok,
  input logic       hdr_crc_err,
  input logic [7:0] msg_start,
  input logic [13:0] msg_count,
  input logic [7:0] msg_seq,
  input logic       data_valid,
  input logic       data_end,
  input logic       data_crc_err,
  input logic       start_seen,
  input logic [1:0] syn_run_q
);
  assert_start_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> syn_run_q == 2'd2);

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_ok |-> ($stable(msg_count) && $stable(msg_seq) && $stable(msg_start)));

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ok && hdr_crc_err));

  assert_no_data_after_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_crc_err |=> !data_valid);

  assert_err_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_crc_err |-> data_end);

  assert_enq_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> msg_start != ENQ_CHAR);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !(data_valid || hdr_ok || hdr_crc_err || data_end));
endmodule

bind ddcmp_rx_framer ddcmp_rx_checker #(.ENQ_CHAR(ENQ_CHAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .hdr_ok(hdr_ok),
  .hdr_crc_err(hdr_crc_err), .msg_start(msg_start), .msg_count(msg_count),
  .msg_seq(msg_seq), .data_valid(data_valid), .data_end(data_end),
  .data_crc_err(data_crc_err), .start_seen(start_seen), .syn_run_q(syn_run_q)
);

// File: tb/ddcmp_rx_framer_tb.sv
module ddcmp_rx_framer_tb;
  localparam int SYN = 8'h96, SOH = 8'h81, ENQ = 8'h05, DLE = 8'h90;

  logic clk = 0, rst_n = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic hdr_ok, hdr_crc_err, data_valid, data_end, data_crc_err;
  logic [7:0] msg_start, msg_resp, msg_seq, msg_addr, data_byte;
  logic [13:0] msg_count;
  logic [1:0] msg_flags;

  always #10 clk = ~clk;

  ddcmp_rx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .hdr_ok(hdr_ok), .hdr_crc_err(hdr_crc_err), .msg_start(msg_start),
    .msg_count(msg_count), .msg_flags(msg_flags), .msg_resp(msg_resp),
    .msg_seq(msg_seq), .msg_addr(msg_addr), .data_valid(data_valid),
    .data_byte(data_byte), .data_end(data_end), .data_crc_err(data_crc_err)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int n_hok = 0, n_herr = 0, n_dv = 0, n_dend = 0, n_derr = 0;

  // expected outputs
  int e_hok, e_herr, e_dv, e_db, e_dend, e_derr;
  int e_start, e_cnt, e_flags, e_resp, e_seq, e_addr;
  // model state
  int m_phase = 0, m_syn = 0, m_rem = 0;
  byte unsigned hq[$];
  byte unsigned dq[$];
  byte unsigned cq[$];

  function automatic int crc_of(byte unsigned q[$]);
    int c = 0;
    foreach (q[k]) begin
      for (int i = 0; i < 8; i++) begin
        int fb = (c ^ (q[k] >> i)) & 1;
        c = c >> 1;
        if (fb != 0) c = c ^ 'hA001;
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(hdr_ok == e_hok[0], "R5 hdr_ok", hdr_ok, e_hok);
    chk(hdr_crc_err == e_herr[0], "R6 hdr_crc_err", hdr_crc_err, e_herr);
    chk(data_valid == e_dv[0], "R7 data_valid", data_valid, e_dv);
    if (e_dv != 0) chk(data_byte == 8'(e_db), "R7 data_byte", data_byte, e_db);
    chk(data_end == e_dend[0], "R8 data_end", data_end, e_dend);
    chk(data_crc_err == e_derr[0], "R8 data_crc_err", data_crc_err, e_derr);
    chk(msg_start == 8'(e_start) && msg_count == 14'(e_cnt) && msg_flags == 2'(e_flags),
        "R3 start/count/flags", {msg_start, msg_count, msg_flags}, (e_start << 16) | (e_cnt << 2) | e_flags);
    chk(msg_resp == 8'(e_resp) && msg_seq == 8'(e_seq) && msg_addr == 8'(e_addr),
        "R3 resp/seq/addr", {msg_resp, msg_seq, msg_addr}, (e_resp << 16) | (e_seq << 8) | e_addr);
    n_hok += hdr_ok; n_herr += hdr_crc_err; n_dv += data_valid;
    n_dend += data_end; n_derr += data_crc_err;
  endtask

  task automatic model(input int b);
    e_hok = 0; e_herr = 0; e_dv = 0; e_dend = 0; e_derr = 0;
    case (m_phase)
      0: begin
        if (b == SYN) m_syn++;
        else if (m_syn >= 2 && (b == SOH || b == ENQ || b == DLE)) begin
          hq.delete(); hq.push_back(8'(b)); m_phase = 1; m_syn = 0;
        end else m_syn = 0;
      end
      1: begin
        hq.push_back(8'(b));
        if (hq.size() == 6) begin m_phase = 2; cq.delete(); end
      end
      2: begin
        cq.push_back(8'(b));
        if (cq.size() == 2) begin
          if (crc_of(hq) == (cq[0] | (cq[1] << 8))) begin
            e_hok = 1;
            e_start = hq[0]; e_cnt = (hq[1] | (hq[2] << 8)) & 'h3FFF;
            e_flags = hq[2] >> 6; e_resp = hq[3]; e_seq = hq[4]; e_addr = hq[5];
            dq.delete(); cq.delete();
            if (hq[0] == ENQ) m_phase = 0;
            else begin m_rem = e_cnt; m_phase = (m_rem == 0) ? 4 : 3; end
          end else begin
            e_herr = 1; m_phase = 0;
          end
        end
      end
      3: begin
        e_dv = 1; e_db = b; dq.push_back(8'(b)); m_rem--;
        if (m_rem == 0) m_phase = 4;
      end
      default: begin
        cq.push_back(8'(b));
        if (cq.size() == 2) begin
          e_dend = 1;
          e_derr = (crc_of(dq) != (cq[0] | (cq[1] << 8)));
          m_phase = 0;
        end
      end
    endcase
  endtask

  task automatic send(input int b);
    @(negedge clk); compare(); model(b);
    rx_valid = 1; rx_byte = 8'(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); compare();
      e_hok = 0; e_herr = 0; e_dv = 0; e_dend = 0; e_derr = 0;
      rx_valid = 0; rx_byte = 8'hA5;
    end
  endtask

  // start, count, flags, resp, seq, addr, payload length, corrupt crc1, corrupt crc2, gap inside
  task automatic msg(input int st, input int cnt, input int fl, input int rs, input int sq,
                     input int ad, input int nd, input bit bad1, input bit bad2, input bit gap);
    byte unsigned h[$];
    byte unsigned d[$];
    int c;
    h = '{8'(st), 8'(cnt), 8'(((cnt >> 8) & 'h3F) | (fl << 6)), 8'(rs), 8'(sq), 8'(ad)};
    send(SYN); send(SYN);
    foreach (h[k]) begin send(h[k]); if (gap && k == 2) idle(2); end
    c = crc_of(h) ^ (bad1 ? 'h0100 : 0);
    send(c & 'hFF); send((c >> 8) & 'hFF);
    for (int i = 0; i < nd; i++) begin
      d.push_back(8'(i * 37 + 5)); send(i * 37 + 5);
      if (gap && i == 0) idle(1);
    end
    if (nd > 0 || (st != ENQ && cnt == 0)) begin
      c = crc_of(d) ^ (bad2 ? 'h0001 : 0);
      send(c & 'hFF); send((c >> 8) & 'hFF);
    end
  endtask

  initial begin
    e_hok = 0; e_herr = 0; e_dv = 0; e_db = 0; e_dend = 0; e_derr = 0;
    e_start = 0; e_cnt = 0; e_flags = 0; e_resp = 0; e_seq = 0; e_addr = 0;
    repeat (3) @(negedge clk);
    compare(); // R1 reset values
    chk(!hdr_ok && !data_valid && msg_count == 0 && msg_addr == 0, "R1 reset", msg_count, 0);
    rst_n = 1;
    idle(2);

    // R3 R4 R5 R7 R8: good data message with a gap (R12)
    msg(SOH, 3, 2'b10, 8'h11, 8'h22, 8'h33, 3, 0, 0, 1);
    idle(2);
    chk(n_hok == 1 && n_dv == 3 && n_dend == 1 && n_derr == 0, "R7 data msg", n_dv, 3);

    // R9: control message, count field ignored
    msg(ENQ, 300, 2'b01, 8'h44, 8'h55, 8'h66, 0, 0, 0, 0);
    send(8'h01); send(8'h02); idle(2);
    chk(n_hok == 2 && n_dv == 3, "R9 enq no data", n_dv, 3);

    // R6: bad header crc, payload bytes not passed
    msg(SOH, 2, 0, 8'h77, 8'h88, 8'h99, 2, 1, 0, 0);
    idle(2);
    chk(n_herr == 1 && n_dv == 3 && msg_resp == 8'h44, "R6 header abort", msg_resp, 8'h44);

    // R8: bad payload crc
    msg(DLE, 1, 2'b11, 8'h12, 8'h34, 8'h56, 1, 0, 1, 0);
    idle(2);
    chk(n_derr == 1 && n_dend == 2, "R8 payload err", n_derr, 1);

    // R11: zero-length data message
    msg(SOH, 0, 0, 8'hAB, 8'hCD, 8'hEF, 0, 0, 0, 0);
    idle(2);
    chk(n_dend == 3 && n_derr == 1 && msg_count == 0, "R11 empty payload", n_dend, 3);

    // R2: single SYN, broken run, start with no run
    send(SYN); send(SOH); send(SYN); send(8'h00); send(SYN); send(ENQ);
    for (int i = 0; i < 10; i++) send(8'h00);
    idle(2);
    chk(n_hok == 4 && n_herr == 1, "R2 short run ignored", n_hok, 4);

    // R10: start straight after a finished message with no new SYNs
    msg(ENQ, 0, 0, 1, 2, 3, 0, 0, 0, 0);
    send(ENQ); for (int i = 0; i < 7; i++) send(8'h00);
    idle(1);
    chk(n_hok == 5, "R10 fresh syn needed", n_hok, 5);

    // R2: longer SYN run still accepted
    send(SYN);
    msg(SOH, 4, 2'b01, 8'hF0, 8'h0F, 8'h5A, 4, 0, 0, 1);
    idle(3);
    chk(n_hok == 6 && n_dv == 8 && n_derr == 1, "R2 long run", n_dv, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule